// File: doc/BRIEF.md
# Serial Transmitter with Queue and Clear-to-Send Pause

This block turns queued bytes into asynchronous serial frames on a single output line. Bytes go into a 16-entry queue through a write port that reports when the queue is full. A shift engine takes them from the queue one at a time. Each frame has a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Between frames the line rests high.

Bit timing comes from an external baud tick. Every bit lasts a fixed number of tick pulses, 16 by default. When the queue holds more data, frames follow each other with no idle gap.

An optional flow-control mode watches an active-low clear-to-send input. The input is synchronized and then looked at only when a new frame could begin. If it goes high partway through a frame, that frame still finishes; the line then stays high until the input returns low. Two sticky flags serve software:
- A queue-low flag, which drives the interrupt request, is set whenever the fill level is at or below a programmable threshold.
- A line-done flag is set when the last queued frame has left the line.

Each flag has its own clear input.

Top module: `serial_tx_flow`

## Requirements
- R1: After reset the line output is 1, the queue-low flag and the interrupt are 1, the line-done flag is 1 and the full indication is 0; the line is 1 whenever no frame is in progress.
- R2: A frame is a 0 start bit, then data bits 0 to 7 least significant first, then a 1 stop bit; each bit lasts exactly 16 baud-tick pulses, and the line changes only on a cycle that carries a tick.
- R3: With parity enabled the parity bit follows data bit 7; with the odd select at 0 (even) it equals the XOR of the data bits, and with the odd select at 1 (odd) it equals the inverse of that XOR.
- R4: The queue sends bytes in write order, holds 16 bytes, raises the full indication while 16 are held, and drops any write made while full.
- R5: When data is queued and sending is allowed, the next start bit begins on the tick that ends the previous stop bit, so start bits are exactly 16 times the frame length in ticks apart.
- R6: With flow control on, a high clear-to-send input never cuts a frame short and prevents any new frame; once the input returns low, the next queued byte goes out beginning with its start bit.
- R7: With flow control off, the clear-to-send input has no effect on transmission.
- R8: The queue-low flag is set on the cycle after the fill level is at or below the threshold. Its clear input lowers it only while the level is above the threshold. The interrupt request equals this flag.
- R9: The line-done flag is set when a stop bit ends with the queue empty, is 0 while a frame is in progress, and its clear input lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| baud_tick | input | 1 | One pulse per oversampling period |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| flow_en | input | 1 | Enable clear-to-send pausing |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| empty_thresh | input | 5 | Fill level at or below which the queue-low flag sets |
| empty_clr | input | 1 | Clear request for the queue-low flag |
| end_clr | input | 1 | Clear request for the line-done flag |
| txd | output | 1 | Serial line |
| tx_empty_flag | output | 1 | Queue-low flag |
| tx_end_flag | output | 1 | Line-done flag |
| irq | output | 1 | Interrupt request |

## Verification
Every one of the 256 byte values is sent once without parity and decoded at mid-bit by a model receiver. This separates bit-order mistakes, stuck data bits and wrong bit lengths. Two further sets of bytes with parity, one even and one odd, each mix odd and even numbers of set bits, so a swapped parity sense shows up.

A burst released after a pause checks that start bits are spaced exactly, with no gap. Raising clear-to-send in the middle of a frame shows that the frame completes and that the byte behind it waits. Overfilling a stalled queue shows which bytes survive. A walk of the fill level across the threshold, with clears tried on both sides of it, exercises the sticky queue-low flag.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sel_e;

   localparam int unsigned STX_FRAME_EXTRA = 3;
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/stx_fifo.sv
module stx_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             do_wr, do_rd;

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned OVS        = 16,
   parameter bit          HAS_PARITY = 1'b1,
   localparam int unsigned FW = W + STX_FRAME_EXTRA,
   localparam int unsigned IW = $clog2(FW),
   localparam int unsigned CW = $clog2(OVS)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         baud_tick,
   input  logic         go,
   input  logic [W-1:0] data,
   input  logic         par_en,
   input  par_sel_e     par_sel,
   output logic         pop,
   output logic         halt,
   output logic         busy,
   output logic         txd
);
   logic [FW-1:0] sh, frame;
   logic [IW-1:0] idx, last, last_nxt;
   logic [CW-1:0] tcnt;
   logic          bit_end, frame_end;

   generate
      if (HAS_PARITY) begin : g_par
         logic pbit;
         assign pbit     = (par_sel == PAR_ODD) ? ~^data : ^data;
         assign frame    = {1'b1, par_en ? pbit : 1'b1, data, 1'b0};
         assign last_nxt = par_en ? IW'(W + 2) : IW'(W + 1);
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_en ^ par_sel;
         assign frame    = {2'b11, data, 1'b0};
         assign last_nxt = IW'(W + 1);
      end
   endgenerate

   assign bit_end   = busy && baud_tick && (tcnt == CW'(OVS - 1));
   assign frame_end = bit_end && (idx == last);
   assign pop       = baud_tick && go && (!busy || frame_end);
   assign halt      = frame_end && !go;
   assign txd       = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         idx  <= '0;
         last <= '0;
         tcnt <= '0;
         busy <= 1'b0;
      end else if (pop) begin
         sh   <= frame;
         idx  <= '0;
         last <= last_nxt;
         tcnt <= '0;
         busy <= 1'b1;
      end else if (halt) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (busy && baud_tick) begin
         if (bit_end) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[FW-1:1]};
            idx  <= idx + 1'b1;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/serial_tx_flow.sv
module serial_tx_flow
   import stx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_PARITY  = 1'b1,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fifo_full,
   input  logic              baud_tick,
   input  logic              cts_n,
   input  logic              flow_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [LVL_W-1:0]  empty_thresh,
   input  logic              empty_clr,
   input  logic              end_clr,
   output logic              txd,
   output logic              tx_empty_flag,
   output logic              tx_end_flag,
   output logic              irq
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $fatal(1, "DEPTH must be a power of two of at least 2");
      end
      if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $fatal(1, "OVS must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $fatal(1, "SYNC_STAGES must be at least 1");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_w
         $fatal(1, "DATA_W must lie in 5..9");
      end
   endgenerate

   logic [DATA_W-1:0] head;
   logic [LVL_W-1:0]  level;
   logic              q_empty, cts_s, go, pop, halt, busy;
   logic              empty_q, end_q;

   stx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(pop), .rd_data(head), .level(level), .full(fifo_full),
      .empty(q_empty)
   );

   stx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
   );

   assign go = !q_empty && (!flow_en || !cts_s);

   stx_shifter #(.W(DATA_W), .OVS(OVS), .HAS_PARITY(HAS_PARITY)) u_shift (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .go(go),
      .data(head), .par_en(par_en), .par_sel(par_sel_e'(par_odd)),
      .pop(pop), .halt(halt), .busy(busy), .txd(txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     empty_q <= 1'b1;
      else if (level <= empty_thresh) empty_q <= 1'b1;
      else if (empty_clr)             empty_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                end_q <= 1'b1;
      else if (pop)              end_q <= 1'b0;
      else if (halt && q_empty)  end_q <= 1'b1;
      else if (end_clr)          end_q <= 1'b0;
   end

   assign tx_empty_flag = empty_q;
   assign tx_end_flag   = end_q;
   assign irq           = empty_q;
endmodule

// File: rtl/stx_chk.sv
module stx_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             baud_tick,
   input logic             txd,
   input logic             busy,
   input logic             flow_en,
   input logic             cts_s,
   input logic [LVL_W-1:0] level,
   input logic [LVL_W-1:0] empty_thresh,
   input logic             tx_empty_flag,
   input logic             tx_end_flag,
   input logic             fifo_full,
   input logic             wr_en,
   input logic             pop
);
   // R1
   idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R2
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && wr_en && !pop) |=> (level == $past(level)));

   // R4
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R6
   cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && cts_s && !busy) |=> !busy);

   // R8
   low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= empty_thresh) |=> tx_empty_flag);

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tx_end_flag);
endmodule

bind serial_tx_flow stx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stx_chk (
   .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .txd(txd),
   .busy(busy), .flow_en(flow_en), .cts_s(cts_s), .level(level),
   .empty_thresh(empty_thresh), .tx_empty_flag(tx_empty_flag),
   .tx_end_flag(tx_end_flag), .fifo_full(fifo_full), .wr_en(wr_en),
   .pop(pop)
);

// File: tb/test_serial_tx_flow.sv
module test_serial_tx_flow;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       fifo_full;
   logic       baud_tick = 1'b0;
   logic       cts_n = 1'b0;
   logic       flow_en = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [4:0] empty_thresh = '0;
   logic       empty_clr = 1'b0;
   logic       end_clr = 1'b0;
   logic       txd, tx_empty_flag, tx_end_flag, irq;

   always #4 clk = ~clk;

   serial_tx_flow i_serial_tx_flow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_full(fifo_full), .baud_tick(baud_tick), .cts_n(cts_n),
      .flow_en(flow_en), .par_en(par_en), .par_odd(par_odd),
      .empty_thresh(empty_thresh), .empty_clr(empty_clr), .end_clr(end_clr),
      .txd(txd), .tx_empty_flag(tx_empty_flag), .tx_end_flag(tx_end_flag),
      .irq(irq)
   );

   int checks = 0;
   int failures = 0;
   int div = 1;
   int tc = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // baud tick generator
   initial begin
      forever begin
         @(posedge clk);
         #1;
         tc++;
         baud_tick = (tc % div == 0);
      end
   end

   // model receiver
   int        exp_q [0:511];
   int        exp_wr = 0, exp_rd = 0, rx_cnt = 0, st_cnt = 0;
   longint    start_ticks [0:511];
   longint    tick_total = 0;
   bit        in_frame = 1'b0, tk;
   int        consumed, nb, kb;
   logic [10:0] fb;

   always @(posedge clk) begin
      tk = baud_tick;
      #2;
      if (tk) tick_total++;
      if (!in_frame) begin
         if (rst_n && txd === 1'b0) begin
            in_frame = 1'b1;
            consumed = 0;
            nb = par_en ? 11 : 10;
            fb = '1;
            start_ticks[rx_cnt] = tick_total;
            st_cnt++;
         end
      end else if (tk) begin
         consumed++;
         if (consumed % 16 == 8) begin
            kb = consumed / 16;
            fb[kb] = txd;
            if (kb == nb - 1) begin
               // R2 start and stop levels
               chk(fb[0] == 1'b0 && fb[nb-1] == 1'b1, "R2 start/stop",
                   {fb[nb-1], fb[0]}, 2'b10);
               // R2 / R4 data and order
               chk(fb[8:1] == exp_q[exp_rd][7:0], "R2 data",
                   fb[8:1], exp_q[exp_rd]);
               if (nb == 11) begin
                  // R3 parity
                  chk(fb[9] == (par_odd ? ~^fb[8:1] : ^fb[8:1]), "R3 parity",
                      fb[9], par_odd ? ~^fb[8:1] : ^fb[8:1]);
               end
               exp_rd++;
               rx_cnt++;
               in_frame = 1'b0;
            end
         end
      end
   end

   task automatic put(input logic [7:0] d, input bit keep);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (keep) begin
         exp_q[exp_wr] = d;
         exp_wr++;
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic wait_rx(input int target);
      while (rx_cnt < target) @(posedge clk);
   endtask

   task automatic wait_idle();
      settle(2);
      while (!(tx_end_flag && !in_frame)) settle(1);
   endtask

   task automatic pulse_empty_clr();
      @(posedge clk); #1 empty_clr = 1'b1;
      @(posedge clk); #1 empty_clr = 1'b0;
   endtask

   task automatic pulse_end_clr();
      @(posedge clk); #1 end_clr = 1'b1;
      @(posedge clk); #1 end_clr = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      settle(1);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd idle", txd, 1);
      chk(tx_empty_flag && irq, "R1 low flag/irq", {tx_empty_flag, irq}, 2'b11);
      chk(tx_end_flag == 1'b1, "R1 end flag", tx_end_flag, 1);
      chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);

      // R2 every byte value, no parity
      for (int b = 0; b < 256; b++) begin
         settle(1);
         while (fifo_full) settle(1);
         put(8'(b), 1'b1);
      end
      wait_rx(256);
      wait_idle();
      chk(rx_cnt == 256, "R2 frame count", rx_cnt, 256);

      // R3 even then odd parity, slower tick
      div = 2;
      par_en = 1'b1;
      for (int p = 0; p < 2; p++) begin
         par_odd = p[0];
         for (int i = 0; i < 24; i++) begin
            settle(1);
            while (fifo_full) settle(1);
            put(8'(i * 37 + 1), 1'b1);
         end
         base = exp_wr;
         wait_rx(base);
         wait_idle();
      end
      par_en = 1'b0;
      div = 1;

      // R5 / R6 burst held then released
      flow_en = 1'b1;
      cts_n = 1'b1;
      base = rx_cnt;
      for (int i = 0; i < 4; i++) put(8'(8'hC0 + i), 1'b1);
      settle(300);
      chk(txd == 1'b1 && st_cnt == base, "R6 blocked start", st_cnt, base);
      cts_n = 1'b0;
      wait_rx(base + 4);
      for (int i = 1; i < 4; i++) begin
         chk(start_ticks[base+i] - start_ticks[base+i-1] == 160, "R5 spacing",
             int'(start_ticks[base+i] - start_ticks[base+i-1]), 160);
      end
      wait_idle();

      // R6 clear-to-send raised mid-frame
      div = 2;
      cts_n = 1'b1;
      base = rx_cnt;
      put(8'h3C, 1'b1);
      put(8'h96, 1'b1);
      cts_n = 1'b0;
      while (st_cnt == base) settle(1);
      settle(100);
      cts_n = 1'b1;
      wait_rx(base + 1);
      settle(800);
      chk(rx_cnt == base + 1 && st_cnt == base + 1 && txd == 1'b1,
          "R6 paused after frame", st_cnt, base + 1);
      chk(tx_end_flag == 1'b0, "R6 end flag with data queued", tx_end_flag, 0);
      cts_n = 1'b0;
      wait_rx(base + 2);
      chk(rx_cnt == base + 2, "R6 resumed", rx_cnt, base + 2);
      wait_idle();
      div = 1;

      // R7 clear-to-send ignored without flow control
      flow_en = 1'b0;
      cts_n = 1'b1;
      base = rx_cnt;
      put(8'h5A, 1'b1);
      wait_rx(base + 1);
      chk(rx_cnt == base + 1, "R7 sent despite cts", rx_cnt, base + 1);
      wait_idle();
      cts_n = 1'b0;

      // R9 line-done flag
      chk(tx_end_flag == 1'b1, "R9 set when drained", tx_end_flag, 1);
      pulse_end_clr();
      settle(1);
      chk(tx_end_flag == 1'b0, "R9 clear input", tx_end_flag, 0);
      base = rx_cnt;
      put(8'hA5, 1'b1);
      while (st_cnt == base) settle(1);
      settle(3);
      chk(tx_end_flag == 1'b0, "R9 low during frame", tx_end_flag, 0);
      wait_rx(base + 1);
      settle(20);
      chk(tx_end_flag == 1'b1, "R9 set after stop", tx_end_flag, 1);

      // R8 queue-low flag around a threshold of 2
      flow_en = 1'b1;
      cts_n = 1'b1;
      empty_thresh = 5'd2;
      base = rx_cnt;
      put(8'h11, 1'b1);
      put(8'h22, 1'b1);
      pulse_empty_clr();
      settle(3);
      chk(tx_empty_flag == 1'b1, "R8 clear ignored at level 2", tx_empty_flag, 1);
      put(8'h33, 1'b1);
      put(8'h44, 1'b1);
      settle(3);
      chk(tx_empty_flag && irq, "R8 sticky above threshold", tx_empty_flag, 1);
      pulse_empty_clr();
      settle(2);
      chk(!tx_empty_flag && !irq, "R8 cleared above threshold",
          {tx_empty_flag, irq}, 0);
      cts_n = 1'b0;
      while (st_cnt < base + 1) settle(1);
      settle(3);
      chk(tx_empty_flag == 1'b0, "R8 level 3 keeps flag low", tx_empty_flag, 0);
      while (st_cnt < base + 2) settle(1);
      settle(3);
      chk(tx_empty_flag && irq, "R8 set at level 2", {tx_empty_flag, irq}, 2'b11);
      wait_rx(base + 4);
      wait_idle();
      empty_thresh = 5'd0;

      // R4 overfill a stalled queue
      cts_n = 1'b1;
      base = rx_cnt;
      for (int i = 0; i < 16; i++) put(8'(8'h40 + i * 3), 1'b1);
      settle(2);
      chk(fifo_full == 1'b1, "R4 full at 16", fifo_full, 1);
      for (int i = 0; i < 4; i++) put(8'(8'hE0 + i), 1'b0);
      settle(2);
      chk(fifo_full == 1'b1, "R4 still full", fifo_full, 1);
      cts_n = 1'b0;
      wait_rx(base + 16);
      wait_idle();
      settle(400);
      chk(rx_cnt == base + 16, "R4 dropped writes", rx_cnt, base + 16);
      chk(fifo_full == 1'b0, "R4 full cleared", fifo_full, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule